// File: doc/BRIEF.md
# Per-Source Interrupt Mask and Pending Controller

This block combines many interrupt sources onto one request line. It supports up to 16 sources. Source 0 stands for the shared overview function and sources 1 to 15 stand for the individual cores. Each source counts its own event pulses in a free-running counter. Each source also holds an acknowledged value that software writes back after it has handled the events. A source is pending for as long as the two values differ.

Software controls masking through a single command word that has a two-bit field per source. The field for source n sits at bits 2n+1:2n of the word. Because of this encoding, one write can mask some sources, unmask others and leave the rest alone. The request output is raised while at least one source is both pending and unmasked. A read port returns the event counter of a selected source, so software knows which value to acknowledge.

Top module: `irqm_ctrl`

## Requirements
- R1: After reset every source is masked (`mask_o` all ones, 1 = masked), every event counter and acknowledged value is zero, `pend_o` is zero and `irq_o` is low.
- R2: A command write whose field n (bits 2n+1:2n of `cmd_wdata_i`) is 2'b01 unmasks source n, and `mask_o[n]` reads 0 from the next cycle on.
- R3: A command write whose field n is 2'b10 masks source n, and `mask_o[n]` reads 1 from the next cycle on.
- R4: A field value of 2'b00 or 2'b11 leaves the mask state of that source unchanged, and so does any cycle with `cmd_we_i` low.
- R5: One write of 0x55555555 unmasks all 16 sources.
- R6: Each cycle with `evt_i[n]` high adds one to the counter of source n. The counter wraps modulo 2^CNT_W (default 32).
- R7: An acknowledge write stores `ack_data_i` as the acknowledged value of source `ack_sel_i` only. Source n is pending (`pend_o[n]`) exactly while its counter differs from its acknowledged value.
- R8: `irq_o` is high exactly while some source is both pending and unmasked. A pending source that is masked does not raise it.
- R9: A command that masks a source and an event on that same source in the same cycle both take effect. The counter increments, the source becomes pending, and `irq_o` stays low until the source is unmasked.
- R10: `rd_cnt_o` shows, in the same cycle, the event counter of the source selected by `rd_sel_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_SRC | Event pulse per source |
| cmd_we_i | input | 1 | Mask command write strobe |
| cmd_wdata_i | input | 2*NUM_SRC | Command word with two bits per source |
| ack_we_i | input | 1 | Acknowledge write strobe |
| ack_sel_i | input | SEL_W | Source to acknowledge |
| ack_data_i | input | CNT_W | Handled counter value |
| rd_sel_i | input | SEL_W | Source whose counter is shown |
| rd_cnt_o | output | CNT_W | Event counter of selected source |
| mask_o | output | NUM_SRC | Mask state per source, 1 = masked |
| pend_o | output | NUM_SRC | Pending flag per source |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A mask command and an event pulse can land on the same source in the same cycle. The two updates travel through separate registers, and neither one is allowed to cancel the other. The bench provokes this case by raising `cmd_wdata_i` field 9 = 2'b10 together with `evt_i[9]` for one clock. It then checks three results: the counter went up by one, the source reads pending and masked, and `irq_o` stays low until a later unmask raises it. A checker property also compares each counter step against its previous value whenever an event arrives, including the cycles in which a mask command arrives as well.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
  typedef enum logic [1:0] {
    CMD_NOP  = 2'b00,
    CMD_ON   = 2'b01,
    CMD_OFF  = 2'b10,
    CMD_NOP2 = 2'b11
  } irq_cmd_e;
endpackage

// File: rtl/irqm_mask_cell.sv
module irqm_mask_cell (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [1:0] cmd_i,
  output logic       masked_o
);
  import irqm_pkg::*;

  irq_cmd_e cmd;
  assign cmd = irq_cmd_e'(cmd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) masked_o <= 1'b1;
    else if (we_i) begin
      case (cmd)
        CMD_ON:  masked_o <= 1'b0;
        CMD_OFF: masked_o <= 1'b1;
        default: masked_o <= masked_o;
      endcase
    end
  end
endmodule

// File: rtl/irqm_src_cnt.sv
module irqm_src_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic             ack_we_i,
  input  logic [CNT_W-1:0] ack_data_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pend_o
);
  logic [CNT_W-1:0] ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      ack_q <= '0;
    end else begin
      if (evt_i)    cnt_o <= cnt_o + 1'b1;
      if (ack_we_i) ack_q <= ack_data_i;
    end
  end

  assign pend_o = (cnt_o != ack_q);
endmodule

// File: rtl/irqm_ctrl.sv
module irqm_ctrl #(
  parameter int NUM_SRC = 16,
  parameter int CNT_W   = 32,
  localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SRC-1:0]   evt_i,
  input  logic                 cmd_we_i,
  input  logic [2*NUM_SRC-1:0] cmd_wdata_i,
  input  logic                 ack_we_i,
  input  logic [SEL_W-1:0]     ack_sel_i,
  input  logic [CNT_W-1:0]     ack_data_i,
  input  logic [SEL_W-1:0]     rd_sel_i,
  output logic [CNT_W-1:0]     rd_cnt_o,
  output logic [NUM_SRC-1:0]   mask_o,
  output logic [NUM_SRC-1:0]   pend_o,
  output logic                 irq_o
);
  logic [NUM_SRC-1:0][CNT_W-1:0] cnt_q;

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    logic ack_hit;
    assign ack_hit = ack_we_i && (ack_sel_i == SEL_W'(n));

    irqm_mask_cell u_mask (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (cmd_we_i),
      .cmd_i    (cmd_wdata_i[2*n+1:2*n]),
      .masked_o (mask_o[n])
    );

    irqm_src_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .evt_i      (evt_i[n]),
      .ack_we_i   (ack_hit),
      .ack_data_i (ack_data_i),
      .cnt_o      (cnt_q[n]),
      .pend_o     (pend_o[n])
    );
  end

  assign rd_cnt_o = cnt_q[rd_sel_i];
  assign irq_o    = |(pend_o & ~mask_o);
endmodule

// File: rtl/irqm_ctrl_chk.sv
module irqm_ctrl_chk #(
  parameter int NUM_SRC = 16,
  parameter int CNT_W   = 32,
  localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [NUM_SRC-1:0]            evt_i,
  input logic                          cmd_we_i,
  input logic [2*NUM_SRC-1:0]          cmd_wdata_i,
  input logic                          ack_we_i,
  input logic [SEL_W-1:0]              ack_sel_i,
  input logic [CNT_W-1:0]              ack_data_i,
  input logic [NUM_SRC-1:0][CNT_W-1:0] cnt_q,
  input logic [NUM_SRC-1:0]            mask_o,
  input logic [NUM_SRC-1:0]            pend_o,
  input logic                          irq_o
);
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_chk
    AST_CMD_UNMASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd_we_i && cmd_wdata_i[2*n+1:2*n] == 2'b01 |=> !mask_o[n]); // R2
    AST_CMD_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd_we_i && cmd_wdata_i[2*n+1:2*n] == 2'b10 |=> mask_o[n]); // R3
    AST_CMD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cmd_we_i || cmd_wdata_i[2*n+1:2*n] == 2'b00 || cmd_wdata_i[2*n+1:2*n] == 2'b11
      |=> $stable(mask_o[n])); // R4
    AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[n] |=> cnt_q[n] == CNT_W'($past(cnt_q[n]) + 1'b1)); // R6
    AST_CNT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !evt_i[n] |=> $stable(cnt_q[n])); // R6
    AST_ACK_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_we_i && ack_sel_i == SEL_W'(n) && !evt_i[n] && ack_data_i == cnt_q[n]
      |=> !pend_o[n]); // R7
  end

  AST_IRQ_ALL_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    &mask_o |-> !irq_o); // R8
  AST_IRQ_NO_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o == '0 |-> !irq_o); // R8
endmodule

bind irqm_ctrl irqm_ctrl_chk #(.NUM_SRC(NUM_SRC), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .evt_i       (evt_i),
  .cmd_we_i    (cmd_we_i),
  .cmd_wdata_i (cmd_wdata_i),
  .ack_we_i    (ack_we_i),
  .ack_sel_i   (ack_sel_i),
  .ack_data_i  (ack_data_i),
  .cnt_q       (cnt_q),
  .mask_o      (mask_o),
  .pend_o      (pend_o),
  .irq_o       (irq_o)
);

// File: tb/irqm_ctrl_bench.sv
module irqm_ctrl_bench;
  localparam int NS = 16;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0]   evt = '0;
  logic            cmd_we = 1'b0;
  logic [2*NS-1:0] cmd_wd = '0;
  logic            ack_we = 1'b0;
  logic [3:0]      ack_sel = '0;
  logic [CW-1:0]   ack_d = '0;
  logic [3:0]      rd_sel = '0;
  logic [CW-1:0]   rd_cnt;
  logic [NS-1:0]   mask, pend;
  logic            irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irqm_ctrl #(.NUM_SRC(NS), .CNT_W(CW)) u_irqm_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .cmd_we_i(cmd_we),
    .cmd_wdata_i(cmd_wd), .ack_we_i(ack_we), .ack_sel_i(ack_sel),
    .ack_data_i(ack_d), .rd_sel_i(rd_sel), .rd_cnt_o(rd_cnt),
    .mask_o(mask), .pend_o(pend), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all drivers start and end at a falling edge
  task automatic wr_cmd(logic [31:0] v);
    cmd_we = 1'b1; cmd_wd = v;
    @(negedge clk);
    cmd_we = 1'b0; cmd_wd = '0;
  endtask

  task automatic pulse(logic [NS-1:0] v);
    evt = v;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic ack(int s, logic [CW-1:0] v);
    ack_we = 1'b1; ack_sel = 4'(s); ack_d = v;
    @(negedge clk);
    ack_we = 1'b0;
  endtask

  task automatic cnt_of(int s, output logic [CW-1:0] v);
    rd_sel = 4'(s);
    #0.1 v = rd_cnt;
  endtask

  task automatic t_reset();
    logic [CW-1:0] c;
    chk("R1 mask", 32'(mask), 32'hFFFF);
    chk("R1 pend", 32'(pend), 0);
    chk("R1 irq", 32'(irq), 0);
    for (int s = 0; s < NS; s++) begin
      cnt_of(s, c);
      chk("R1 cnt", 32'(c), 0);
    end
  endtask

  task automatic t_fields();
    wr_cmd(32'h0000_0040);
    chk("R2 unmask field3", 32'(mask), 32'hFFF7);
    wr_cmd(32'hFFFF_FFFF);
    chk("R4 code 11", 32'(mask), 32'hFFF7);
    wr_cmd(32'h0000_0000);
    chk("R4 code 00", 32'(mask), 32'hFFF7);
    wr_cmd(32'h0000_0080);
    chk("R3 mask field3", 32'(mask), 32'hFFFF);
    wr_cmd(32'h4000_0001);
    chk("R2 fields 0 and 15", 32'(mask), 32'h7FFE);
    wr_cmd(32'h5555_5555);
    chk("R5 unmask all", 32'(mask), 32'h0000);
  endtask

  task automatic t_count_ack();
    logic [CW-1:0] c;
    pulse(16'h0020); pulse(16'h0020); pulse(16'h0020);
    cnt_of(5, c);
    chk("R6 R10 cnt5", 32'(c), 3);
    chk("R7 pend5", 32'(pend), 32'h0020);
    chk("R8 irq on", 32'(irq), 1);
    ack(2, 8'h00);
    chk("R7 other ack", 32'(pend), 32'h0020);
    ack(5, 8'h02);
    chk("R7 partial ack", 32'(pend), 32'h0020);
    ack(5, 8'h03);
    chk("R7 full ack", 32'(pend), 0);
    chk("R8 irq off", 32'(irq), 0);
  endtask

  task automatic t_masked_pend();
    wr_cmd(32'h0000_8000);
    pulse(16'h0080);
    chk("R8 masked pend", 32'(pend), 32'h0080);
    chk("R8 masked irq", 32'(irq), 0);
    wr_cmd(32'h0000_4000);
    chk("R8 unmasked irq", 32'(irq), 1);
    ack(7, 8'h01);
    chk("R8 cleared", 32'(irq), 0);
  endtask

  task automatic t_same_cycle();
    logic [CW-1:0] c;
    cmd_we = 1'b1; cmd_wd = 32'h0008_0000; evt = 16'h0200;
    @(negedge clk);
    cmd_we = 1'b0; cmd_wd = '0; evt = '0;
    cnt_of(9, c);
    chk("R9 cnt9", 32'(c), 1);
    chk("R9 mask9", 32'(mask[9]), 1);
    chk("R9 pend9", 32'(pend), 32'h0200);
    chk("R9 irq held", 32'(irq), 0);
    wr_cmd(32'h0004_0000);
    chk("R9 irq after unmask", 32'(irq), 1);
    ack(9, 8'h01);
  endtask

  task automatic t_wrap();
    logic [CW-1:0] c;
    evt = 16'h1000;
    for (int i = 0; i < 255; i++) @(negedge clk);
    evt = '0;
    cnt_of(12, c);
    chk("R6 cnt 255", 32'(c), 255);
    chk("R7 pend 12", 32'(pend), 32'h1000);
    pulse(16'h1000);
    cnt_of(12, c);
    chk("R6 wrap", 32'(c), 0);
    chk("R7 pend after wrap", 32'(pend), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_count_ack();
    t_masked_pend();
    t_same_cycle();
    t_wrap();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule